// File: doc/BRIEF.md
# Four-Lane Packed Multiply-Accumulate with Wide Slices

This block speeds up dot products and filter loops on packed 16-bit data. Each operand word carries four signed 16-bit lanes. When the strobe is high, every lane multiplies its two halves, sign-extends the 32-bit product, and adds it into a 48-bit slice reserved for that lane. The four slices sit side by side in one 192-bit accumulator register. The 16 extra guard bits per lane let long loops run without wrapping, so software need not check for overflow inside the loop.

A clear control empties the accumulator at the start of a new sum. In a second mode it instead loads the first products directly, which saves one cycle per loop. The full 192-bit accumulator can be read out. A packed 64-bit view is also provided: it clamps each slice to the signed 16-bit range, so results can go back into ordinary lane data. The unit accepts a new operand pair every cycle.

Top module: `packed_mac_wide`

## Requirements
- R1: While reset is active (rst_n low) and right after it, `acc_out`, `packed_out` and `out_valid` are all zero.
- R2: When `in_valid` is high and `acc_clr` is low, slice i (`acc_out[48i+47:48i]`) gains the signed product of lane i of `op_a` and `op_b` (lane i is bits `[16i+15:16i]`). The product is sign-extended to 48 bits. This happens for i = 0..3 in the same edge.
- R3: The accumulator changes at the first clock edge after the strobe. `out_valid` is high exactly in the cycle after an accepted strobe, so back-to-back strobes keep it high.
- R4: When `in_valid` and `acc_clr` are both low, every slice holds its value.
- R5: When `acc_clr` is high and `clr_load` is 0, every slice becomes zero, and any strobe in that cycle is ignored.
- R6: When `acc_clr` is high and `clr_load` is 1, each slice is loaded with its lane's sign-extended product if `in_valid` is high, and with zero otherwise.
- R7: Lane i of `packed_out` (bits `[16i+15:16i]`) holds slice i clamped to the signed 16-bit range. Values above 32767 read as 16'h7FFF, values below -32768 read as 16'h8000, and all other values read as their low 16 bits.
- R8: Slices are independent. A slice growing past 32 bits, including from the -32768 × -32768 corner product, never changes a neighbouring slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand strobe; a multiply-accumulate is requested this cycle |
| acc_clr | input | 1 | Clear request for all slices |
| clr_load | input | 1 | Clear flavour: 0 zeroes, 1 loads the current products |
| op_a | input | 64 | Four signed 16-bit lanes, first factor |
| op_b | input | 64 | Four signed 16-bit lanes, second factor |
| acc_out | output | 192 | Full accumulator, four 48-bit slices |
| packed_out | output | 64 | Per-lane saturated 16-bit readback |
| out_valid | output | 1 | High the cycle after an accepted strobe |

## Verification
The bench builds the block with its default parameters: four lanes, 16-bit lanes and 48-bit slices. With these values the saturation limits can be reached after a single product. Repeating the most negative lane value 200 times pushes one slice well past 32 bits, so carry isolation between slices can be seen at the ports. A full 48-bit wrap would need more than 2^17 worst-case steps, so it stays out of reach.

// File: rtl/pmac_pkg.sv
package pmac_pkg;
    typedef enum logic {
        CLR_ZERO = 1'b0,
        CLR_LOAD = 1'b1
    } clr_mode_e;
endpackage

// File: rtl/pmac_lane.sv
module pmac_lane #(
    parameter int LANE_W = 16,
    parameter int ACC_W  = 48
) (
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    input  logic [ACC_W-1:0]  acc_in,
    output logic [ACC_W-1:0]  prod_ext,
    output logic [ACC_W-1:0]  sum
);
    localparam int PROD_W = 2 * LANE_W;
    localparam int EXT_W  = ACC_W - PROD_W;

    logic signed [PROD_W-1:0] prod;

    always_comb begin
        prod     = $signed(a) * $signed(b);
        prod_ext = {{EXT_W{prod[PROD_W-1]}}, prod};
        sum      = acc_in + prod_ext;
    end

    initial begin
        a_r8_guard_bits: assert (ACC_W > PROD_W)
            else $error("slice too narrow for product");
    end
endmodule

// File: rtl/pmac_sat.sv
module pmac_sat #(
    parameter int LANE_W = 16,
    parameter int ACC_W  = 48
) (
    input  logic [ACC_W-1:0]  slice,
    output logic [LANE_W-1:0] q
);
    localparam logic [ACC_W-1:0] HI_LIM = {{(ACC_W-LANE_W+1){1'b0}}, {(LANE_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] LO_LIM = {{(ACC_W-LANE_W+1){1'b1}}, {(LANE_W-1){1'b0}}};

    always_comb begin
        if ($signed(slice) > $signed(HI_LIM))
            q = HI_LIM[LANE_W-1:0];
        else if ($signed(slice) < $signed(LO_LIM))
            q = LO_LIM[LANE_W-1:0];
        else
            q = slice[LANE_W-1:0];
    end
endmodule

// File: rtl/packed_mac_wide.sv
module packed_mac_wide #(
    parameter int LANES  = 4,
    parameter int LANE_W = 16,
    parameter int ACC_W  = 48
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     acc_clr,
    input  logic                     clr_load,
    input  logic [LANES*LANE_W-1:0]  op_a,
    input  logic [LANES*LANE_W-1:0]  op_b,
    output logic [LANES*ACC_W-1:0]   acc_out,
    output logic [LANES*LANE_W-1:0]  packed_out,
    output logic                     out_valid
);
    import pmac_pkg::*;

    localparam int TOT_W = LANES * ACC_W;

    typedef struct packed {
        logic [TOT_W-1:0] acc;
        logic             vld;
    } state_t;

    state_t    st_d, st_q;
    clr_mode_e mode;

    logic [ACC_W-1:0] prod_ext [LANES];
    logic [ACC_W-1:0] sum      [LANES];

    assign mode = clr_mode_e'(clr_load);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        pmac_lane #(.LANE_W(LANE_W), .ACC_W(ACC_W)) u_lane (
            .a        (op_a[g*LANE_W +: LANE_W]),
            .b        (op_b[g*LANE_W +: LANE_W]),
            .acc_in   (st_q.acc[g*ACC_W +: ACC_W]),
            .prod_ext (prod_ext[g]),
            .sum      (sum[g])
        );

        pmac_sat #(.LANE_W(LANE_W), .ACC_W(ACC_W)) u_sat (
            .slice (st_q.acc[g*ACC_W +: ACC_W]),
            .q     (packed_out[g*LANE_W +: LANE_W])
        );

        // R7: an unclamped readback lane equals its slice
        a_r7_readback: assert property (@(posedge clk) disable iff (!rst_n)
            (packed_out[g*LANE_W +: LANE_W] != {1'b0, {(LANE_W-1){1'b1}}} &&
             packed_out[g*LANE_W +: LANE_W] != {1'b1, {(LANE_W-1){1'b0}}})
            |-> ({{(ACC_W-LANE_W){packed_out[g*LANE_W+LANE_W-1]}},
                  packed_out[g*LANE_W +: LANE_W]} == acc_out[g*ACC_W +: ACC_W]));
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        for (int i = 0; i < LANES; i++) begin
            if (acc_clr) begin
                if (mode == CLR_LOAD && in_valid)
                    st_d.acc[i*ACC_W +: ACC_W] = prod_ext[i];
                else
                    st_d.acc[i*ACC_W +: ACC_W] = '0;
            end else if (in_valid) begin
                st_d.acc[i*ACC_W +: ACC_W] = sum[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign acc_out   = st_q.acc;
    assign out_valid = st_q.vld;

    a_r3_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r3_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !acc_clr) |=> $stable(acc_out));

    a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_clr && !clr_load) |=> (acc_out == '0));

    a_r6_load_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_clr && clr_load && !in_valid) |=> (acc_out == '0));
endmodule

// File: tb/sim_packed_mac_wide.sv
module sim_packed_mac_wide;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid, acc_clr, clr_load;
    logic [63:0]  op_a, op_b;
    logic [191:0] acc_out;
    logic [63:0]  packed_out;
    logic         out_valid;

    int     n_chk  = 0;
    int     n_fail = 0;
    bit     done   = 1'b0;
    longint exp_acc [4];
    logic   exp_vld;

    always #10 clk = ~clk;

    packed_mac_wide u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .acc_clr(acc_clr),
        .clr_load(clr_load), .op_a(op_a), .op_b(op_b), .acc_out(acc_out),
        .packed_out(packed_out), .out_valid(out_valid)
    );

    // {op_a, op_b, in_valid, acc_clr, clr_load}
    localparam logic [130:0] TBL [8] = '{
        {64'h0001_0002_0003_0004, 64'h0005_0006_0007_0008, 3'b100}, // R2
        {64'hFFFF_FFFE_8000_7FFF, 64'h0003_0002_0001_7FFF, 3'b100}, // R2
        {64'h1234_EDCC_0000_0101, 64'hFFFF_0010_7FFF_FF00, 3'b100}, // R2
        {64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 3'b000}, // R4 idle
        {64'h0100_0100_0100_0100, 64'h0100_0100_0100_0100, 3'b111}, // R6 load
        {64'h8000_8000_8000_8000, 64'h8000_7FFF_0001_FFFF, 3'b100}, // R2
        {64'h7FFF_7FFF_7FFF_7FFF, 64'h7FFF_7FFF_7FFF_7FFF, 3'b110}, // R5 clear
        {64'h0007_FFF9_0007_FFF9, 64'h0003_0003_FFFD_FFFD, 3'b100}  // R2
    };

    function automatic logic [15:0] sat16(longint v);
        if (v > 32767)       return 16'h7FFF;
        else if (v < -32768) return 16'h8000;
        else                 return v[15:0];
    endfunction

    task automatic check_all(string req);
        for (int i = 0; i < 4; i++) begin
            longint got = longint'($signed(acc_out[i*48 +: 48]));
            n_chk++;
            if (got != exp_acc[i]) begin
                n_fail++;
                $display("FAIL %s slice%0d actual=%0d expected=%0d", req, i, got, exp_acc[i]);
            end
            n_chk++;
            if (packed_out[i*16 +: 16] != sat16(exp_acc[i])) begin
                n_fail++;
                $display("FAIL R7 (%s) lane%0d actual=%h expected=%h", req, i,
                         packed_out[i*16 +: 16], sat16(exp_acc[i]));
            end
        end
        n_chk++;
        if (out_valid !== exp_vld) begin
            n_fail++;
            $display("FAIL R3 (%s) out_valid actual=%b expected=%b", req, out_valid, exp_vld);
        end
    endtask

    // called at a negedge; result checked at the following negedge
    task automatic step(logic [63:0] a, logic [63:0] b, logic v, logic c, logic l, string req);
        op_a = a; op_b = b; in_valid = v; acc_clr = c; clr_load = l;
        for (int i = 0; i < 4; i++) begin
            longint p = longint'($signed(a[i*16 +: 16])) * longint'($signed(b[i*16 +: 16]));
            if (c)      exp_acc[i] = (l && v) ? p : 0;
            else if (v) exp_acc[i] = exp_acc[i] + p;
        end
        exp_vld = v;
        @(posedge clk);
        @(negedge clk);
        check_all(req);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R3 watchdog actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b1; acc_clr = 1'b0; clr_load = 1'b0;
        op_a = 64'h7FFF_7FFF_7FFF_7FFF; op_b = 64'h7FFF_7FFF_7FFF_7FFF;
        for (int i = 0; i < 4; i++) exp_acc[i] = 0;
        exp_vld = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all("R1 in reset");
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_all("R1 after reset");

        // table walk: R2 accumulate, R4 hold, R5 clear, R6 load, R3 valid
        for (int k = 0; k < 8; k++)
            step(TBL[k][130:67], TBL[k][66:3], TBL[k][2], TBL[k][1], TBL[k][0], "R2/R4/R5/R6 table");

        // R4: several idle cycles
        step(64'hAAAA_5555_AAAA_5555, 64'h1234_1234_1234_1234, 1'b0, 1'b0, 1'b0, "R4 idle a");
        step(64'h0, 64'h0, 1'b0, 1'b0, 1'b0, "R4 idle b");

        // R6: load mode without strobe gives zero
        step(64'h7FFF_7FFF_7FFF_7FFF, 64'h7FFF_7FFF_7FFF_7FFF, 1'b0, 1'b1, 1'b1, "R6 load idle");

        // R7: negative saturation, then positive
        step(64'h8000_8000_0001_0000, 64'h7FFF_0001_0001_0000, 1'b1, 1'b0, 1'b0, "R7 neg");
        step(64'h8000_8000_0001_0000, 64'h7FFF_0001_0001_0000, 1'b1, 1'b0, 1'b0, "R7 neg");
        step(64'h7FFF_0000_7FFF_0000, 64'h7FFF_0000_0001_0000, 1'b1, 1'b0, 1'b0, "R7 pos");

        // R8: corner product repeated back to back (R3 valid stays high)
        step(64'h0, 64'h0, 1'b0, 1'b1, 1'b0, "R5 clear before R8");
        for (int k = 0; k < 200; k++)
            step(64'h0000_8000_0000_8000, 64'h0000_8000_0000_8000, 1'b1, 1'b0, 1'b0, "R8 no carry");
        step(64'h0, 64'h0, 1'b0, 1'b0, 1'b0, "R3 valid drop");

        // R5: clear ignores a simultaneous strobe
        step(64'h0003_0003_0003_0003, 64'h0003_0003_0003_0003, 1'b1, 1'b1, 1'b0, "R5 clear with strobe");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule